// File: doc/BRIEF.md
# Display Command and Address Sequencer

This block sits behind the host port of a combined text and bitmap display controller. Each byte the host writes is marked as either an instruction or data. Instructions change the block's state. There are two instruction sets. A basic set covers clearing, the home position, address direction, the display, cursor and blink switches, and text and user-font addressing. An extended set covers graphics enable, the scroll/address select switch, the scroll offset, per-line inversion and bitmap addressing. One bit of the function-set instruction picks between the two sets, and that choice stays in force until a later function-set instruction changes it.

Data bytes are collected in pairs, high byte first. Each finished pair becomes one 16-bit write strobe toward the text RAM, the user-font RAM or the bitmap RAM, at the address the counter held before the pair. A clear instruction writes the space code into every text word, one word per cycle. Every accepted byte starts a busy window of a fixed number of clocks, and the block ignores any writes that arrive while that window is open.

Top module: `disp_seq`

## Requirements
- R1: The block issues one `ram_we` pulse for each completed data pair. The pulse comes in the cycle after the second byte is accepted and carries `ram_wdata` = {first byte, second byte}, `ram_addr` = the counter value before the pair, and `ram_tgt` = 0 for text, 1 for user font, or 2 for bitmap.
- R2: After a text or user-font pair, the 6-bit counter steps by +1 when `inc_dir`=1 and by -1 when `inc_dir`=0, wrapping modulo 64. In the basic set, entry mode is 0000_01xy, and bit 1 (x) sets `inc_dir`.
- R3: Clear is instruction 01h in the basic set. It writes 2020h to text addresses 0 through 63 in that order, in consecutive cycles, starting the cycle after acceptance. It sets the counter to 0, selects text and forces `inc_dir`=1. Busy stays high for the whole fill, which is 64 cycles.
- R4: Home is 02h or 03h in the basic set. It sets the counter to 0, selects text and issues no RAM write.
- R5: Display control is 0000_1DCB in the basic set. It sets `disp_on` from bit 2, `cursor_on` from bit 1 and `blink_on` from bit 0.
- R6: Function set is 001x_xRGx. Bit 2 sets `ext_set`. Bit 1 updates `gfx_on` only when `ext_set` was already 1.
- R7: In the basic set, 1xxx_xxxx loads the counter with bits 5:0 and selects text, so 80h–BFh reach lines 1–4. The pattern 01xx_xxxx loads bits 5:0 and selects user font only when `scroll_sel`=0. Otherwise the counter is left unchanged.
- R8: In the extended set, 0000_001S sets `scroll_sel`. 0000_01ab toggles `rev_flags[ab]`. 01xx_xxxx with `scroll_sel`=1 loads `scroll_ofs` from bits 5:0.
- R9: In the extended set, two consecutive 1xxx_xxxx instructions set the bitmap address. The first sets the row from bits 5:0, the second sets the column from bits 3:0 and selects bitmap. `cur_addr` = {row, column}.
- R10: After each bitmap pair, the column increments and wraps from 15 to 0. The row does not change, and `inc_dir` has no effect on bitmap stepping.
- R11: Every accepted byte raises `busy` from the next cycle for `BUSY_CYCLES` cycles. Bytes written while `busy`=1 are ignored.
- R12: An accepted instruction discards a half-finished data pair. An accepted byte that is not the second bitmap address instruction cancels a pending bitmap row.
- R13: After reset, `busy`, `ram_we`, `cur_addr`, `disp_on`, `cursor_on`, `blink_on`, `ext_set`, `gfx_on`, `scroll_sel`, `rev_flags` and `scroll_ofs` are all 0, and `inc_dir`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_is_data | input | 1 | 1 = data byte, 0 = instruction byte |
| wr_byte | input | 8 | Written byte |
| busy | output | 1 | Execution in progress; writes ignored |
| cur_addr | output | V_W+H_W | Current counter address ({row,column} for bitmap) |
| ram_we | output | 1 | RAM word write pulse |
| ram_tgt | output | 2 | RAM selected by the pulse |
| ram_addr | output | V_W+H_W | RAM word address |
| ram_wdata | output | 16 | RAM word data |
| inc_dir | output | 1 | Counter direction, 1 = up |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| ext_set | output | 1 | Extended instruction set selected |
| gfx_on | output | 1 | Graphics enable |
| scroll_sel | output | 1 | 1 = scroll offset, 0 = user-font addressing |
| rev_flags | output | 4 | Per-line inversion flags |
| scroll_ofs | output | V_W | Vertical scroll offset |

## Verification
State and counter outputs settle in the cycle after the accepting edge, and the bench reads them at the falling edge that follows. A pair's RAM strobe appears in that same cycle. The 64 clear writes follow on the next 64 cycles. The driver pushes every expected strobe into a queue before it writes the byte that triggers it. A monitor pops the queue at each falling edge where `ram_we` is high, so a write that is late, extra or missing shows up as a mismatch or as a leftover item. Busy lengths are measured by counting falling edges until `busy` drops: `BUSY_CYCLES` for ordinary bytes and 64 for a clear.

// File: rtl/disp_seq_pkg.sv
// Shared types for the display command sequencer.
// Assumes 8-bit host bytes and 16-bit RAM words.
package disp_seq_pkg;

    typedef enum logic [1:0] {
        TGT_TEXT   = 2'd0,
        TGT_FONT   = 2'd1,
        TGT_BITMAP = 2'd2
    } tgt_t;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISPCTL,
        OP_FUNC,
        OP_FONT_ADDR,
        OP_TEXT_ADDR,
        OP_SR,
        OP_REVERSE,
        OP_SCROLL,
        OP_BMP_ADDR
    } op_t;

endpackage

// File: rtl/disp_cmd_decode.sv
// Instruction byte classifier.
// Maps a byte to an operation, given the active instruction set and the
// scroll/address select switch. Purely combinational.
module disp_cmd_decode
    import disp_seq_pkg::*;
(
    input  logic [7:0] ins,
    input  logic       ext,
    input  logic       sr,
    output op_t        op
);

    // Priority decode on the leading one of the instruction byte.
    always_comb begin
        if (ins[7])      op = ext ? OP_BMP_ADDR : OP_TEXT_ADDR;
        else if (ins[6]) op = ext ? (sr ? OP_SCROLL : OP_NONE)
                                  : (sr ? OP_NONE : OP_FONT_ADDR);
        else if (ins[5]) op = OP_FUNC;
        else if (ins[4]) op = OP_NONE;
        else if (ins[3]) op = ext ? OP_NONE : OP_DISPCTL;
        else if (ins[2]) op = ext ? OP_REVERSE : OP_ENTRY;
        else if (ins[1]) op = ext ? OP_SR : OP_HOME;
        else if (ins[0]) op = ext ? OP_NONE : OP_CLEAR;
        else             op = OP_NONE;
    end

endmodule

// File: rtl/disp_busy_timer.sv
// Execution window timer.
// Reloads to CYCLES on each accepted byte and counts down to zero.
// Assumes CYCLES >= 1.
module disp_busy_timer #(
    parameter int CYCLES = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Reload on load, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= CW'(CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

endmodule

// File: rtl/disp_text_fill.sv
// Text RAM fill walker.
// On start, steps an index through every text word, one per cycle.
// Assumes start never arrives while a fill is already running.
module disp_text_fill #(
    parameter int AC_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            active,
    output logic [AC_W-1:0] idx
);

    // Run from index 0 to the last word, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            idx <= idx + 1'b1;
            if (idx == '1) active <= 1'b0;
        end
    end

endmodule

// File: rtl/disp_addr_ctr.sv
// Address counter for text, user-font and bitmap RAMs.
// Text/font use a 6-bit wrapping counter stepped in either direction;
// bitmap uses a row and a column, where only the column steps and wraps.
// Assumes AC_W <= V_W + H_W.
module disp_addr_ctr
    import disp_seq_pkg::*;
#(
    parameter int AC_W = 6,
    parameter int V_W  = 6,
    parameter int H_W  = 4,
    localparam int ADDR_W = V_W + H_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero,
    input  logic              ld_text,
    input  logic              ld_font,
    input  logic              ld_row,
    input  logic              ld_col,
    input  logic              step,
    input  logic              up,
    input  logic [AC_W-1:0]   ac_val,
    input  logic [V_W-1:0]    row_val,
    input  logic [H_W-1:0]    col_val,
    output tgt_t              tgt,
    output logic [ADDR_W-1:0] addr
);

    logic [AC_W-1:0] ac;
    logic [V_W-1:0]  row;
    logic [H_W-1:0]  col;

    // Load, clear and step the counter fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac  <= '0;
            row <= '0;
            col <= '0;
            tgt <= TGT_TEXT;
        end else begin
            if (zero) begin
                ac  <= '0;
                tgt <= TGT_TEXT;
            end else if (ld_text) begin
                ac  <= ac_val;
                tgt <= TGT_TEXT;
            end else if (ld_font) begin
                ac  <= ac_val;
                tgt <= TGT_FONT;
            end else if (ld_col) begin
                col <= col_val;
                tgt <= TGT_BITMAP;
            end else if (step) begin
                if (tgt == TGT_BITMAP) col <= col + 1'b1;
                else if (up)           ac  <= ac + 1'b1;
                else                   ac  <= ac - 1'b1;
            end
            if (ld_row) row <= row_val;
        end
    end

    // Present the address of the selected RAM.
    always_comb begin
        if (tgt == TGT_BITMAP) addr = {row, col};
        else                   addr = {{(ADDR_W-AC_W){1'b0}}, ac};
    end

endmodule

// File: rtl/disp_seq.sv
// Display command and address sequencer (top).
// Accepts host instruction/data bytes when not busy, keeps mode state,
// pairs data bytes into 16-bit RAM writes and runs the text clear fill.
// Assumes the host holds wr_en for one clock per byte.
module disp_seq
    import disp_seq_pkg::*;
#(
    parameter int          BUSY_CYCLES = 18000,
    parameter int          AC_W        = 6,
    parameter int          V_W         = 6,
    parameter int          H_W         = 4,
    parameter logic [15:0] FILL_CODE   = 16'h2020,
    localparam int         ADDR_W      = V_W + H_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_is_data,
    input  logic [7:0]        wr_byte,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              ram_we,
    output logic [1:0]        ram_tgt,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [15:0]       ram_wdata,
    output logic              inc_dir,
    output logic              disp_on,
    output logic              cursor_on,
    output logic              blink_on,
    output logic              ext_set,
    output logic              gfx_on,
    output logic              scroll_sel,
    output logic [3:0]        rev_flags,
    output logic [V_W-1:0]    scroll_ofs
);

    op_t             op;
    tgt_t            ctr_tgt;
    logic            accept, acc_ins, acc_dat, pair_done;
    logic            half, row_pend;
    logic [7:0]      hi_byte;
    logic            timer_busy, fill_busy;
    logic [AC_W-1:0] fill_idx;
    logic            is_clear, is_bmp;

    disp_cmd_decode u_dec (
        .ins (wr_byte),
        .ext (ext_set),
        .sr  (scroll_sel),
        .op  (op)
    );

    // Acceptance and per-operation qualifiers.
    always_comb begin
        accept    = wr_en && !busy;
        acc_ins   = accept && !wr_is_data;
        acc_dat   = accept && wr_is_data;
        pair_done = acc_dat && half;
        is_clear  = acc_ins && (op == OP_CLEAR);
        is_bmp    = acc_ins && (op == OP_BMP_ADDR);
    end

    disp_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .active (timer_busy)
    );

    disp_text_fill #(.AC_W(AC_W)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (is_clear),
        .active (fill_busy),
        .idx    (fill_idx)
    );

    assign busy = timer_busy || fill_busy;

    disp_addr_ctr #(.AC_W(AC_W), .V_W(V_W), .H_W(H_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .zero    (acc_ins && (op == OP_CLEAR || op == OP_HOME)),
        .ld_text (acc_ins && (op == OP_TEXT_ADDR)),
        .ld_font (acc_ins && (op == OP_FONT_ADDR)),
        .ld_row  (is_bmp && !row_pend),
        .ld_col  (is_bmp && row_pend),
        .step    (pair_done),
        .up      (inc_dir),
        .ac_val  (wr_byte[AC_W-1:0]),
        .row_val (wr_byte[V_W-1:0]),
        .col_val (wr_byte[H_W-1:0]),
        .tgt     (ctr_tgt),
        .addr    (cur_addr)
    );

    // Byte pairing and pending bitmap row tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half     <= 1'b0;
            hi_byte  <= '0;
            row_pend <= 1'b0;
        end else if (accept) begin
            if (acc_ins)    half <= 1'b0;
            else            half <= !half;
            if (acc_dat && !half) hi_byte <= wr_byte;
            row_pend <= is_bmp && !row_pend;
        end
    end

    // Mode registers updated by accepted instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_dir    <= 1'b1;
            disp_on    <= 1'b0;
            cursor_on  <= 1'b0;
            blink_on   <= 1'b0;
            ext_set    <= 1'b0;
            gfx_on     <= 1'b0;
            scroll_sel <= 1'b0;
            rev_flags  <= '0;
            scroll_ofs <= '0;
        end else if (acc_ins) begin
            case (op)
                OP_CLEAR:   inc_dir <= 1'b1;
                OP_ENTRY:   inc_dir <= wr_byte[1];
                OP_DISPCTL: begin
                    disp_on   <= wr_byte[2];
                    cursor_on <= wr_byte[1];
                    blink_on  <= wr_byte[0];
                end
                OP_FUNC: begin
                    ext_set <= wr_byte[2];
                    if (ext_set) gfx_on <= wr_byte[1];
                end
                OP_SR:      scroll_sel <= wr_byte[0];
                OP_REVERSE: rev_flags[wr_byte[1:0]] <= !rev_flags[wr_byte[1:0]];
                OP_SCROLL:  scroll_ofs <= wr_byte[V_W-1:0];
                default:    ;
            endcase
        end
    end

    // Registered RAM write port: fill words or completed data pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_tgt   <= TGT_TEXT;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else if (fill_busy) begin
            ram_we    <= 1'b1;
            ram_tgt   <= TGT_TEXT;
            ram_addr  <= {{(ADDR_W-AC_W){1'b0}}, fill_idx};
            ram_wdata <= FILL_CODE;
        end else if (pair_done) begin
            ram_we    <= 1'b1;
            ram_tgt   <= ctr_tgt;
            ram_addr  <= cur_addr;
            ram_wdata <= {hi_byte, wr_byte};
        end else begin
            ram_we    <= 1'b0;
        end
    end

endmodule

// File: rtl/disp_seq_chk.sv
// Assertion checker for disp_seq, attached with bind below.
// Assumes the bound signals keep the top module's names and meaning.
module disp_seq_chk
    import disp_seq_pkg::*;
#(
    parameter int V_W = 6,
    parameter int H_W = 4,
    parameter int MODE_W = 17,
    localparam int ADDR_W = V_W + H_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic              fill_busy,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              ram_we,
    input logic [1:0]        ram_tgt,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              inc_dir,
    input logic [3:0]        rev_flags,
    input logic [MODE_W-1:0] mode_vec
);

    // R11: an accepted byte opens the busy window on the next cycle.
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> busy);

    // R11: a byte offered while busy changes neither address nor modes.
    a_r11_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(cur_addr) && $stable(mode_vec)));

    // R10: a bitmap write keeps the row and advances the column by one.
    a_r10_bitmap_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_tgt == TGT_BITMAP) |->
        (cur_addr[ADDR_W-1:H_W] == ram_addr[ADDR_W-1:H_W]) &&
        (cur_addr[H_W-1:0] == ram_addr[H_W-1:0] + 1'b1));

    // R8: at most one inversion flag flips per cycle.
    a_r8_single_flag_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rev_flags ^ $past(rev_flags)) <= 1);

    // R3: a starting fill comes with counter at zero and upward direction.
    a_r3_clear_resets_ctr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy) |-> (inc_dir && cur_addr == '0));

endmodule

bind disp_seq disp_seq_chk #(
    .V_W    (V_W),
    .H_W    (H_W),
    .MODE_W (11 + V_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .fill_busy (fill_busy),
    .cur_addr  (cur_addr),
    .ram_we    (ram_we),
    .ram_tgt   (ram_tgt),
    .ram_addr  (ram_addr),
    .inc_dir   (inc_dir),
    .rev_flags (rev_flags),
    .mode_vec  ({inc_dir, disp_on, cursor_on, blink_on, ext_set, gfx_on,
                 scroll_sel, rev_flags, scroll_ofs})
);

// File: tb/disp_seq_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for disp_seq: expected RAM writes are queued by the
// driver and matched by a monitor; state outputs are checked directly.
module disp_seq_tb;

    localparam int BC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_is_data = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        busy;
    logic [9:0]  cur_addr;
    logic        ram_we;
    logic [1:0]  ram_tgt;
    logic [9:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic        inc_dir, disp_on, cursor_on, blink_on, ext_set, gfx_on, scroll_sel;
    logic [3:0]  rev_flags;
    logic [5:0]  scroll_ofs;

    int n_chk = 0;
    int n_fail = 0;
    logic [27:0] exp_q[$];

    always #2 clk = ~clk;

    disp_seq #(.BUSY_CYCLES(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_data(wr_is_data),
        .wr_byte(wr_byte), .busy(busy), .cur_addr(cur_addr), .ram_we(ram_we),
        .ram_tgt(ram_tgt), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .inc_dir(inc_dir), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .ext_set(ext_set), .gfx_on(gfx_on),
        .scroll_sel(scroll_sel), .rev_flags(rev_flags), .scroll_ofs(scroll_ofs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [1:0] t, input logic [9:0] a, input logic [15:0] d);
        exp_q.push_back({t, a, d});
    endtask

    // Drive one byte after busy clears; returns at the falling edge after acceptance.
    task automatic put(input logic d, input logic [7:0] b);
        while (busy) @(negedge clk);
        wr_en = 1'b1; wr_is_data = d; wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Monitor: every RAM write must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected ram write", {4'h0, ram_tgt, ram_addr, ram_wdata}, 32'h0);
            end else begin
                logic [27:0] e;
                e = exp_q.pop_front();
                check("R1 R3 R10 ram write", {4'h0, ram_tgt, ram_addr, ram_wdata}, {4'h0, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 busy", busy, 0);
        check("R13 cur_addr", cur_addr, 0);
        check("R13 inc_dir", inc_dir, 1);
        check("R13 modes", {disp_on, cursor_on, blink_on, ext_set, gfx_on, scroll_sel}, 0);
        check("R13 rev/scroll", {rev_flags, scroll_ofs}, 0);
        check("R13 ram_we", ram_we, 0);

        // R5 and R11 busy length
        put(0, 8'h0C);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R11 busy length", n, BC);
        check("R5 display 0C", {disp_on, cursor_on, blink_on}, 3'b100);
        put(0, 8'h0F);
        check("R5 display 0F", {disp_on, cursor_on, blink_on}, 3'b111);

        // R6 graphics bit ignored in basic set
        put(0, 8'h32);
        check("R6 basic G ignored", {ext_set, gfx_on}, 2'b00);

        // R3 clear after switching direction down
        put(0, 8'h04);
        check("R2 entry down", inc_dir, 0);
        wait_idle();
        for (int i = 0; i < 64; i++) expect_wr(2'd0, 10'(i), 16'h2020);
        put(0, 8'h01);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R3 clear busy length", n, 64);
        check("R3 clear counter", cur_addr, 0);
        check("R3 clear inc_dir", inc_dir, 1);

        // R7 text address, R1 pairing, R2 increment
        put(0, 8'h85);
        check("R7 text addr", cur_addr, 5);
        expect_wr(2'd0, 10'd5, 16'h1234);
        put(1, 8'h12);
        put(1, 8'h34);
        check("R2 step up", cur_addr, 6);

        // R2 decrement and wrap
        put(0, 8'h04);
        expect_wr(2'd0, 10'd6, 16'hABCD);
        put(1, 8'hAB);
        put(1, 8'hCD);
        check("R2 step down", cur_addr, 5);
        put(0, 8'h80);
        expect_wr(2'd0, 10'd0, 16'hAA55);
        put(1, 8'hAA);
        put(1, 8'h55);
        check("R2 wrap below zero", cur_addr, 63);

        // R12 half pair discarded, R4 home
        put(0, 8'h06);
        put(0, 8'h90);
        check("R7 line 2 addr", cur_addr, 16);
        put(1, 8'h11);
        put(0, 8'h02);
        check("R4 home", cur_addr, 0);
        expect_wr(2'd0, 10'd0, 16'h2233);
        put(1, 8'h22);
        put(1, 8'h33);
        check("R12 pair restarted", cur_addr, 1);

        // R7 user-font address
        put(0, 8'h45);
        check("R7 font addr", cur_addr, 5);
        expect_wr(2'd1, 10'd5, 16'h0FF0);
        put(1, 8'h0F);
        put(1, 8'hF0);
        check("R2 font step", cur_addr, 6);

        // R6 extended set and graphics
        put(0, 8'h34);
        check("R6 ext on", {ext_set, gfx_on}, 2'b10);
        put(0, 8'h36);
        check("R6 gfx on", {ext_set, gfx_on}, 2'b11);

        // R8 reverse toggles
        put(0, 8'h05);
        check("R8 reverse line1", rev_flags, 4'b0010);
        put(0, 8'h07);
        check("R8 reverse line3", rev_flags, 4'b1010);
        put(0, 8'h05);
        check("R8 reverse untoggle", rev_flags, 4'b1000);

        // R8 scroll select and offset; R7 font address blocked
        put(0, 8'h03);
        check("R8 scroll_sel", scroll_sel, 1);
        put(0, 8'h4A);
        check("R8 scroll_ofs", scroll_ofs, 6'h0A);
        put(0, 8'h32);
        check("R6 back to basic", {ext_set, gfx_on}, 2'b01);
        put(0, 8'h47);
        check("R7 font addr blocked", cur_addr, 6);
        put(0, 8'h36);
        put(0, 8'h02);
        check("R8 scroll_sel off", scroll_sel, 0);

        // R9 bitmap address, R10 column wrap
        put(0, 8'hA1);
        put(0, 8'h8E);
        check("R9 bitmap addr", cur_addr, 10'h21E);
        expect_wr(2'd2, 10'h21E, 16'h1111);
        expect_wr(2'd2, 10'h21F, 16'h2222);
        expect_wr(2'd2, 10'h210, 16'h3333);
        put(1, 8'h11); put(1, 8'h11);
        put(1, 8'h22); put(1, 8'h22);
        put(1, 8'h33); put(1, 8'h33);
        check("R10 column wrap row kept", cur_addr, 10'h211);

        // R11 write during busy is ignored
        put(0, 8'h32);
        wr_en = 1'b1; wr_is_data = 1'b0; wr_byte = 8'h08;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        check("R11 busy write ignored", disp_on, 1);
        check("R11 addr kept", cur_addr, 10'h211);

        repeat (4) @(negedge clk);
        check("R1 all writes seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule